// File: doc/BRIEF.md
# Scalable SAR Conversion Controller

This block is the digital sequencer of a charge-redistribution successive-approximation converter that offers two resolutions, 12 bits and 8 bits. A one-cycle start request launches a conversion. The sequencer then steps through four fixed phases: it clears the capacitor arrays, builds the auto-zero reference while the comparator nulls its offset, acquires the input, and finally resolves the code one bit per trial, most significant bit first. Because purge and auto-zero come first, sampling happens a fixed number of ticks after the start request.

Trials are self-timed. The latch model's two outputs both rest high. As soon as exactly one of them falls, the controller commits the bit and presents the next trial value to the DAC, so a fast decision shortens the conversion. A stall guard forces a zero decision if the latch has not resolved within a programmable window, and it records that event in a sticky flag. At the end of a conversion the controller raises done, drops its own clock enable and powers down the comparator until the next accepted start. The resolution mode also chooses which comparator gain path is enabled.

The controller runs on a tick that is half a bit period. The default auto-zero length of three ticks therefore equals one and a half bit periods.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, done, timeout, result, the clock enable, comparator power, both path enables and all phase outputs are 0, and latch_rst is 1.
- R2: A start accepted while idle raises purge on the next tick. Purge lasts PURGE_TICKS (2) ticks, auto-zero lasts AZ_TICKS (3) ticks, and sample lasts SAMPLE_TICKS (2) ticks, in that order. Bit cycling follows. At most one of purge, azero, sample and cycling is high in any tick.
- R3: Trials run from the most significant bit down, and the first trial drives dac_code = 12'h800. A trial keeps its bit when latch_p=1 and latch_n=0 (input at or above the DAC value) and clears it when latch_p=0 and latch_n=1. In 12-bit mode (mode_hi=1) the result equals the input code.
- R4: In 8-bit mode (mode_hi=0) exactly 8 trials run on bits 11..4, and result[3:0] is 0.
- R5: Each trial takes one re-arm tick (latch_rst=1) plus resolve ticks until the latch decides. With a latch delay of d ticks and a window of W ticks, a trial lasts 1+min(d+1,W) ticks. done is first seen 7 + (sum of trial lengths) + 1 ticks after the start edge.
- R6: If both latch outputs are still high in the WDOG_TICKS-th (2) resolve tick, the bit is forced to 0 and timeout is set. Timeout stays set after the conversion ends.
- R7: An accepted start clears timeout and done on the next tick.
- R8: While a conversion is active, path_long_en equals the mode captured at start, and path_short_en equals its inverse. Both are 0 when idle.
- R9: On completion done rises. clk_en and comp_pwr fall together with it. result and done then hold until the next accepted start.
- R10: A start that arrives during a conversion is ignored. A change of mode_hi during a conversion has no effect, because the mode is captured when the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (half a bit period) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only while idle |
| mode_hi | input | 1 | 1 selects 12-bit, 0 selects 8-bit resolution |
| latch_p | input | 1 | Latch output; falls when input is below the DAC value |
| latch_n | input | 1 | Latch output; falls when input is at or above the DAC value |
| dac_code | output | 12 | Trial code driven to the capacitor arrays |
| purge | output | 1 | Array purge phase |
| azero | output | 1 | Auto-zero reference and comparator null phase |
| sample | output | 1 | Input acquisition phase |
| cycling | output | 1 | Bit-trial phase |
| latch_rst | output | 1 | Holds the latch in reset (low only while resolving) |
| path_long_en | output | 1 | Enables the three-stage preamplifier path |
| path_short_en | output | 1 | Enables the single-stage preamplifier path |
| comp_pwr | output | 1 | Comparator power enable |
| clk_en | output | 1 | Clock enable of the sequencer (low when gated) |
| result | output | 12 | Last completed code, left-aligned in 8-bit mode |
| done | output | 1 | Conversion complete |
| timeout | output | 1 | Sticky flag: a decision was forced in this conversion |

## Verification
Purge is due on the first falling edge after the edge that samples start. Each phase length and the done tick follow from the formula in R5, using the latch delay that the bench model was given. The bench drives every input on a falling edge and samples every output on the next falling edge, counting ticks from the start edge. It compares done's first appearance against the computed tick count, and checks the result, timeout and enables at that same tick. Code sweeps cover every 8-bit code and a spread of 12-bit codes, with latch delays of 0 and 1. Extra cases cover a stalled latch, a stall on the first trial only, and stimulus injected in the middle of a conversion.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PURGE   = 3'd1,
    PH_AZERO   = 3'd2,
    PH_SAMPLE  = 3'd3,
    PH_REARM   = 3'd4,
    PH_RESOLVE = 3'd5
  } phase_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned PURGE_TICKS  = 2,
  parameter int unsigned AZ_TICKS     = 3,
  parameter int unsigned SAMPLE_TICKS = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   step_next,
  input  logic   conv_end,
  output phase_t phase,
  output logic   accept,
  output logic   sample_last
);
  localparam int unsigned MAXT = max3(PURGE_TICKS, AZ_TICKS, SAMPLE_TICKS);
  localparam int unsigned CW   = cnt_width(MAXT);
  localparam logic [CW-1:0] P_END = CW'(PURGE_TICKS - 1);
  localparam logic [CW-1:0] A_END = CW'(AZ_TICKS - 1);
  localparam logic [CW-1:0] S_END = CW'(SAMPLE_TICKS - 1);

  phase_t        phase_q;
  logic [CW-1:0] tick;

  assign phase       = phase_q;
  assign accept      = start && (phase_q == PH_IDLE);
  assign sample_last = (phase_q == PH_SAMPLE) && (tick == S_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tick    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          tick <= '0;
          if (accept) phase_q <= PH_PURGE;
        end
        PH_PURGE: begin
          if (tick == P_END) begin
            phase_q <= PH_AZERO;
            tick    <= '0;
          end else begin
            tick <= tick + CW'(1);
          end
        end
        PH_AZERO: begin
          if (tick == A_END) begin
            phase_q <= PH_SAMPLE;
            tick    <= '0;
          end else begin
            tick <= tick + CW'(1);
          end
        end
        PH_SAMPLE: begin
          if (tick == S_END) begin
            phase_q <= PH_REARM;
            tick    <= '0;
          end else begin
            tick <= tick + CW'(1);
          end
        end
        PH_REARM: phase_q <= PH_RESOLVE;
        PH_RESOLVE: begin
          if (conv_end)       phase_q <= PH_IDLE;
          else if (step_next) phase_q <= PH_REARM;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_stall_guard.sv
module sar_stall_guard
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned WDOG_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic resolving,
  input  logic decided,
  output logic force_dec
);
  localparam int unsigned CW = cnt_width(WDOG_TICKS);
  localparam logic [CW-1:0] W_END = CW'(WDOG_TICKS - 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !resolving || decided) wait_cnt <= '0;
    else if (wait_cnt != W_END)       wait_cnt <= wait_cnt + CW'(1);
  end

  assign force_dec = resolving && !decided && (wait_cnt == W_END);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned NB    = 12,
  parameter int unsigned NB_LO = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          mode_in,
  input  logic          arm,
  input  logic          commit,
  input  logic          keep,
  input  logic          forced,
  output logic [NB-1:0] code,
  output logic          mode_q,
  output logic          last_bit,
  output logic [NB-1:0] result,
  output logic          done,
  output logic          timeout
);
  localparam int unsigned IW     = cnt_width(NB);
  localparam int unsigned LO_LSB = NB - NB_LO;

  logic [IW-1:0] idx;
  logic [IW-1:0] lsb_idx;
  logic [NB-1:0] settled;
  logic [NB-1:0] next_code;

  generate
    if (NB_LO >= NB) begin : g_single
      assign lsb_idx = '0;
    end else begin : g_dual
      assign lsb_idx = mode_q ? '0 : IW'(LO_LSB);
    end
  endgenerate

  assign last_bit = (idx == lsb_idx);

  always_comb begin
    settled      = code;
    settled[idx] = keep;
    next_code    = settled;
    if (!last_bit) next_code[idx - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= '0;
      idx     <= '0;
      mode_q  <= 1'b1;
      result  <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else if (load) begin
      code    <= '0;
      idx     <= IW'(NB - 1);
      mode_q  <= mode_in;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else if (arm) begin
      code[NB-1] <= 1'b1;
    end else if (commit) begin
      if (forced) timeout <= 1'b1;
      code <= next_code;
      if (last_bit) begin
        result <= settled;
        done   <= 1'b1;
      end else begin
        idx <= idx - IW'(1);
      end
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned NB           = 12,
  parameter int unsigned NB_LO        = 8,
  parameter int unsigned PURGE_TICKS  = 2,
  parameter int unsigned AZ_TICKS     = 3,
  parameter int unsigned SAMPLE_TICKS = 2,
  parameter int unsigned WDOG_TICKS   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_hi,
  input  logic          latch_p,
  input  logic          latch_n,
  output logic [NB-1:0] dac_code,
  output logic          purge,
  output logic          azero,
  output logic          sample,
  output logic          cycling,
  output logic          latch_rst,
  output logic          path_long_en,
  output logic          path_short_en,
  output logic          comp_pwr,
  output logic          clk_en,
  output logic [NB-1:0] result,
  output logic          done,
  output logic          timeout
);
  phase_t phase;
  logic   accept, sample_last;
  logic   resolving, decided, above, force_dec;
  logic   commit, keep, last_bit, mode_q;
  logic   step_next, conv_end;

  assign resolving = (phase == PH_RESOLVE);
  assign decided   = resolving && (latch_p ^ latch_n);
  assign above     = latch_p && !latch_n;
  assign commit    = decided || force_dec;
  assign keep      = decided && above;
  assign step_next = commit && !last_bit;
  assign conv_end  = commit && last_bit;

  sar_phase_seq #(
    .PURGE_TICKS (PURGE_TICKS),
    .AZ_TICKS    (AZ_TICKS),
    .SAMPLE_TICKS(SAMPLE_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .step_next  (step_next),
    .conv_end   (conv_end),
    .phase      (phase),
    .accept     (accept),
    .sample_last(sample_last)
  );

  sar_stall_guard #(.WDOG_TICKS(WDOG_TICKS)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .resolving(resolving),
    .decided  (decided),
    .force_dec(force_dec)
  );

  sar_approx_reg #(.NB(NB), .NB_LO(NB_LO)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .mode_in (mode_hi),
    .arm     (sample_last),
    .commit  (commit),
    .keep    (keep),
    .forced  (force_dec),
    .code    (dac_code),
    .mode_q  (mode_q),
    .last_bit(last_bit),
    .result  (result),
    .done    (done),
    .timeout (timeout)
  );

  assign purge         = (phase == PH_PURGE);
  assign azero         = (phase == PH_AZERO);
  assign sample        = (phase == PH_SAMPLE);
  assign cycling       = (phase == PH_REARM) || resolving;
  assign latch_rst     = !resolving;
  assign clk_en        = (phase != PH_IDLE);
  assign comp_pwr      = clk_en;
  assign path_long_en  = clk_en && mode_q;
  assign path_short_en = clk_en && !mode_q;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned NB    = 12,
  parameter int unsigned NB_LO = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          latch_p,
  input logic          latch_n,
  input logic [NB-1:0] dac_code,
  input logic          purge,
  input logic          azero,
  input logic          sample,
  input logic          cycling,
  input logic          latch_rst,
  input logic          path_long_en,
  input logic          path_short_en,
  input logic          comp_pwr,
  input logic          clk_en,
  input logic [NB-1:0] result,
  input logic          done,
  input logic          timeout
);
  localparam logic [NB-1:0] MSB_ONLY = {1'b1, {(NB-1){1'b0}}};

  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({purge, azero, sample, cycling}));

  assert_purge_first_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !clk_en) |=> purge);

  assert_az_after_purge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(azero) |-> $past(purge));

  assert_sample_after_az_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sample) |-> $past(azero));

  assert_first_trial_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cycling) |-> (dac_code == MSB_ONLY));

  assert_left_align_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $past(path_short_en)) |-> (result[NB-NB_LO-1:0] == '0));

  assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(cycling && !latch_rst && latch_p && latch_n));

  assert_paths_R8: assert property (@(posedge clk) disable iff (rst)
    !(path_long_en && path_short_en) && ((path_long_en || path_short_en) == comp_pwr));

  assert_done_gated_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!clk_en && !comp_pwr));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(result));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    (start && (sample || cycling)) |=> !purge);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NB(NB), .NB_LO(NB_LO)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .latch_p      (latch_p),
  .latch_n      (latch_n),
  .dac_code     (dac_code),
  .purge        (purge),
  .azero        (azero),
  .sample       (sample),
  .cycling      (cycling),
  .latch_rst    (latch_rst),
  .path_long_en (path_long_en),
  .path_short_en(path_short_en),
  .comp_pwr     (comp_pwr),
  .clk_en       (clk_en),
  .result       (result),
  .done         (done),
  .timeout      (timeout)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  localparam int W  = 2;
  localparam int PA = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_i = 1'b1;
  logic latch_p, latch_n;
  logic [11:0] dac_code, result;
  logic purge, azero, sample, cycling, latch_rst;
  logic path_long_en, path_short_en, comp_pwr, clk_en, done, timeout;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int vin = 0;
  int cur_d = 0;
  bit slow_msb = 1'b0;
  logic [3:0] lcnt;
  int dly_eff;

  // stats filled by run_conv
  int lat, pc, ac, sc, ord_err, path_err, trial_err;
  bit tmo_first, done_first;

  always #10 clk = ~clk;

  sar_conv_ctrl uut (
    .clk(clk), .rst(rst), .start(start), .mode_hi(mode_i),
    .latch_p(latch_p), .latch_n(latch_n), .dac_code(dac_code),
    .purge(purge), .azero(azero), .sample(sample), .cycling(cycling),
    .latch_rst(latch_rst), .path_long_en(path_long_en),
    .path_short_en(path_short_en), .comp_pwr(comp_pwr), .clk_en(clk_en),
    .result(result), .done(done), .timeout(timeout)
  );

  // behavioural latch with programmable decision delay
  always_ff @(posedge clk) begin
    cycles <= cycles + 1;
    if (latch_rst)          lcnt <= 4'd0;
    else if (lcnt != 4'hF)  lcnt <= lcnt + 4'd1;
  end

  assign dly_eff = (slow_msb && dac_code == 12'h800) ? 3 : cur_d;

  always_comb begin
    if (!latch_rst && int'(lcnt) >= dly_eff) begin
      latch_p = (vin >= int'({20'd0, dac_code}));
      latch_n = !(vin >= int'({20'd0, dac_code}));
    end else begin
      latch_p = 1'b1;
      latch_n = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input bit m, input int d, input bit slow,
                          input bit extra_start, input bit flip_mode);
    int prev_ph;
    int ph;
    bit seen_trial;
    @(negedge clk);
    vin = v; mode_i = m; cur_d = d; slow_msb = slow; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; pc = 0; ac = 0; sc = 0; ord_err = 0; path_err = 0; trial_err = 0;
    prev_ph = 0; seen_trial = 1'b0;
    tmo_first = timeout; done_first = done;
    while (!done && lat < 400) begin
      ph = purge ? 1 : azero ? 2 : sample ? 3 : cycling ? 4 : 0;
      if (ph == 0 || ph < prev_ph) ord_err++;
      prev_ph = ph;
      if (purge) pc++;
      if (azero) ac++;
      if (sample) sc++;
      if (path_long_en != m || path_short_en != !m || !comp_pwr || !clk_en) path_err++;
      if (cycling && !seen_trial) begin
        seen_trial = 1'b1;
        if (dac_code != 12'h800) trial_err++;
      end
      start  = (extra_start && lat == 12);
      if (flip_mode && lat == 9) mode_i = !m;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    mode_i = m;
  endtask

  function automatic int trial_len(input int d);
    return 1 + (((d + 1) < W) ? (d + 1) : W);
  endfunction

  function automatic int exp_lat(input bit m, input int d, input bit slow);
    int n;
    int s;
    n = m ? 12 : 8;
    s = n * trial_len(d);
    if (slow) s = s - trial_len(d) + trial_len(9);
    return PA + s + 1;
  endfunction

  task automatic check_conv(input string tag, input bit m, input int d, input bit slow,
                            input int exp_res, input bit exp_tmo);
    chk(done_first == 1'b0 && tmo_first == 1'b0, {tag, " R7 flags cleared by start"},
        int'(done_first) + int'(tmo_first), 0);
    chk(pc == 2 && ac == 3 && sc == 2 && ord_err == 0, {tag, " R2 phase lengths/order"},
        pc * 100 + ac * 10 + sc + ord_err * 1000, 232);
    chk(trial_err == 0, {tag, " R3 first trial code"}, trial_err, 0);
    chk(path_err == 0, {tag, " R8 path enables"}, path_err, 0);
    chk(lat == exp_lat(m, d, slow), {tag, " R5 done latency"}, lat, exp_lat(m, d, slow));
    chk(int'(result) == exp_res, {tag, " R3/R4 result code"}, int'(result), exp_res);
    chk(timeout == exp_tmo, {tag, " R6 timeout flag"}, int'(timeout), int'(exp_tmo));
    chk(!clk_en && !comp_pwr && !path_long_en && !path_short_en, {tag, " R9 gated at done"},
        int'(clk_en) + int'(comp_pwr), 0);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    mismatched++;
    compared++;
    $display("FAIL R5 watchdog expired actual=%0d expected=<150000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !timeout && result == 12'd0 && !clk_en && !comp_pwr, "R1 reset flags",
        int'(done) + int'(timeout) + int'(result) + int'(clk_en), 0);
    chk(!purge && !azero && !sample && !cycling && latch_rst && !path_long_en && !path_short_en,
        "R1 reset phases", int'(purge) + int'(cycling), 0);

    // R4 exhaustive 8-bit sweep, latch delay 0 or 1
    for (int c = 0; c < 256; c++) begin
      int v8 = c * 16 + (c % 16);
      run_conv(v8, 1'b0, c % 2, 1'b0, 1'b0, 1'b0);
      check_conv("R4 sweep8", 1'b0, c % 2, 1'b0, v8 & 12'hFF0, 1'b0);
    end

    // R3 12-bit sweep
    for (int v = 0; v < 4096; v += 13) begin
      run_conv(v, 1'b1, (v / 13) % 2, 1'b0, 1'b0, 1'b0);
      check_conv("R3 sweep12", 1'b1, (v / 13) % 2, 1'b0, v, 1'b0);
    end
    run_conv(4095, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check_conv("R3 fullscale", 1'b1, 0, 1'b0, 4095, 1'b0);
    run_conv(2047, 1'b1, 1, 1'b0, 1'b0, 1'b0);
    check_conv("R3 midscale-1", 1'b1, 1, 1'b0, 2047, 1'b0);

    // R6 stalled latch on every trial: all bits forced to 0
    run_conv(1234, 1'b1, 3, 1'b0, 1'b0, 1'b0);
    check_conv("R6 all stalled", 1'b1, 3, 1'b0, 0, 1'b1);
    // R9 hold after done
    r = int'(result);
    repeat (3) @(negedge clk);
    chk(done && timeout && int'(result) == r && !clk_en, "R9 hold after done",
        int'(result), r);
    // R7 next start clears timeout
    run_conv(1234, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check_conv("R7 recover", 1'b1, 0, 1'b0, 1234, 1'b0);

    // R6 stall only on the first trial
    run_conv(3000, 1'b1, 0, 1'b1, 1'b0, 1'b0);
    check_conv("R6 msb stall 12b", 1'b1, 0, 1'b1, 12'h7FF, 1'b1);
    run_conv(3000, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    check_conv("R6 msb stall 8b", 1'b0, 0, 1'b1, 12'h7F0, 1'b1);

    // R10 start during conversion ignored, mode change ignored
    run_conv(2900, 1'b1, 0, 1'b0, 1'b1, 1'b0);
    check_conv("R10 busy start", 1'b1, 0, 1'b0, 2900, 1'b0);
    run_conv(1717, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    check_conv("R10 mode flip 8b", 1'b0, 1, 1'b0, 1717 & 12'hFF0, 1'b0);
    run_conv(1717, 1'b1, 0, 1'b0, 1'b0, 1'b1);
    check_conv("R10 mode flip 12b", 1'b1, 0, 1'b0, 1717, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule